// File: doc/BRIEF.md
# Tagged Extended-Precision Register Stack

This block holds eight 80-bit extended-precision values in a circular register file. A 3-bit top pointer selects which physical register is the logical head of the stack. Values arrive already in extended format: a sign bit, a 15-bit exponent and a 64-bit significand. The block can push a value, pop the head, and read or overwrite any entry by its depth below the head. Arithmetic, rounding and format conversion belong to the surrounding datapath.

Every physical register carries a 2-bit tag that says whether it is empty or what kind of value it holds. The tag is worked out from the value itself on each push and each write, and is set to empty on each pop. The block refuses a push into an occupied register and a pop from an empty one. In either case it reports a stack fault, uses a direction flag to say which of the two occurred, and leaves its contents unchanged.

Top module: `fp_regstack`

## Requirements
- R1: After an asynchronous reset, or in the cycle after the synchronous `init` input is sampled high, `tag_word` is 16'hFFFF, `top` is 0 and the three fault outputs are low. `init` overrides any push, pop or write in the same cycle.
- R2: A push that is accepted writes `push_data` into physical register (`top` − 1) mod 8 and moves `top` to that register. Starting from the initial state, the first push therefore lands in register 7.
- R3: Each pushed or written value is tagged from its fields. Exponent all ones gives 2'b10 (special). Exponent zero with a nonzero significand also gives 2'b10. Exponent zero with a zero significand gives 2'b01 (zero). Any other value gives 2'b00 (valid). Code 2'b11 means empty. Register i's tag is `tag_word[2i+1:2i]`.
- R4: A pop that is accepted sets the tag of the head register to 2'b11 and moves `top` to (`top` + 1) mod 8.
- R5: `rd_data` and `rd_tag` combinationally show physical register (`top` + `rd_idx`) mod 8.
- R6: When `wr_en` is high, `wr_data` and its tag are written into physical register (`top` + `wr_idx`) mod 8. The write is ignored in any cycle that also has push or pop high.
- R7: A push whose target register is not empty is refused. In the next cycle `stack_fault`, `invalid` and `c1` are high for one cycle.
- R8: A pop when the head register is empty is refused. In the next cycle `stack_fault` and `invalid` are high and `c1` is low. The fault outputs are low after any cycle that had no refused operation.
- R9: A refused push or pop leaves `top`, every tag and every data register unchanged.
- R10: When push and pop are both high, the push is carried out and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous re-initialise: all registers empty, top 0 |
| push | input | 1 | Push `push_data` |
| push_data | input | 80 | Value to push |
| pop | input | 1 | Pop the head |
| rd_idx | input | 3 | Depth below head for the read port |
| rd_data | output | 80 | Value at depth `rd_idx` |
| rd_tag | output | 2 | Tag at depth `rd_idx` |
| wr_en | input | 1 | Overwrite the entry at depth `wr_idx` |
| wr_idx | input | 3 | Depth below head for the write port |
| wr_data | input | 80 | Value to write |
| top | output | 3 | Physical register number of the head |
| tag_word | output | 16 | All eight tags, register i at bits 2i+1:2i |
| stack_fault | output | 1 | Previous cycle had a refused push or pop |
| c1 | output | 1 | With a fault: 1 for a refused push, 0 for a refused pop |
| invalid | output | 1 | Invalid-operation flag raised with every stack fault |

## Verification
A corrupted top pointer shows up immediately as a wrong `top`. It also moves every relative read: `rd_data` for a given `rd_idx` then comes from the wrong register in the same cycle. A wrong tag becomes visible on `tag_word` right after the edge that stored it. If the empty check is wrong, the damage surfaces on the next push or pop: a fault is missing or spurious one cycle later, or data that should have been kept is overwritten. The tests fill the stack past its depth and drain it past empty, so both directions of wraparound and both fault kinds appear at the ports.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
   typedef enum logic [1:0] {
      TAG_VALID   = 2'b00,
      TAG_ZERO    = 2'b01,
      TAG_SPECIAL = 2'b10,
      TAG_EMPTY   = 2'b11
   } tag_e;
endpackage

// File: rtl/fpstk_classify.sv
module fpstk_classify #(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int DATA_W = 1 + EXP_W + MAN_W
) (
   input  logic [DATA_W-1:0] value,
   output fpstk_pkg::tag_e   tag
);
   import fpstk_pkg::*;

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] mant;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fpstk_classify: EXP_W must be at least 2");
   end

   assign expo = value[MAN_W +: EXP_W];
   assign mant = value[MAN_W-1:0];

   always_comb begin
      if (&expo)
         tag = TAG_SPECIAL;
      else if (expo == '0)
         tag = (mant == '0) ? TAG_ZERO : TAG_SPECIAL;
      else
         tag = TAG_VALID;
   end
endmodule

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             dec,
   input  logic             inc,
   output logic [PTR_W-1:0] top
);
   if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("fpstk_ptr: DEPTH must be a power of two, at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     top <= '0;
      else if (init)  top <= '0;
      else if (dec)   top <= top - 1'b1;
      else if (inc)   top <= top + 1'b1;
   end

   AST_PTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !inc) else $error("pointer asked to move both ways"); // R10
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 80,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      init,
   input  logic                      wr_en,
   input  logic [PTR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  fpstk_pkg::tag_e           wr_tag,
   input  logic                      clr_en,
   input  logic [PTR_W-1:0]          clr_addr,
   input  logic [PTR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]         rd_data,
   output logic [DEPTH-1:0][1:0]     tags
);
   import fpstk_pkg::*;

   logic [DEPTH-1:0][DATA_W-1:0] regs;

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      logic hit_wr;
      logic hit_clr;
      assign hit_wr  = wr_en  && (wr_addr  == PTR_W'(i));
      assign hit_clr = clr_en && (clr_addr == PTR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
            tags[i] <= TAG_EMPTY;
         end else if (init) begin
            tags[i] <= TAG_EMPTY;
         end else if (hit_wr) begin
            regs[i] <= wr_data;
            tags[i] <= wr_tag;
         end else if (hit_clr) begin
            tags[i] <= TAG_EMPTY;
         end
      end
   end

   assign rd_data = regs[rd_addr];

   AST_WRITE_CLEAR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> !wr_en) else $error("write and clear in one cycle"); // R6
endmodule

// File: rtl/fp_regstack.sv
module fp_regstack #(
   parameter int DEPTH = 8,
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int DATA_W = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_tag,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PTR_W-1:0]  top,
   output logic [2*DEPTH-1:0] tag_word,
   output logic              stack_fault,
   output logic              c1,
   output logic              invalid
);
   import fpstk_pkg::*;

   logic [DEPTH-1:0][1:0] tags;
   logic [PTR_W-1:0]      push_tgt, rd_addr, wr_addr, st_addr;
   logic                  push_req, pop_req, wr_req;
   logic                  push_ok, pop_ok, push_bad, pop_bad;
   logic [DATA_W-1:0]     st_data;
   tag_e                  st_tag;

   assign push_req = push && !init;
   assign pop_req  = pop && !push && !init;
   assign wr_req   = wr_en && !push && !pop && !init;

   assign push_tgt = top - 1'b1;
   assign rd_addr  = top + rd_idx;
   assign wr_addr  = top + wr_idx;

   assign push_ok  = push_req && (tags[push_tgt] == TAG_EMPTY);
   assign push_bad = push_req && !push_ok;
   assign pop_ok   = pop_req && (tags[top] != TAG_EMPTY);
   assign pop_bad  = pop_req && !pop_ok;

   assign st_addr = push_ok ? push_tgt  : wr_addr;
   assign st_data = push_ok ? push_data : wr_data;

   fpstk_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
      .value (st_data),
      .tag   (st_tag)
   );

   fpstk_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (init),
      .dec   (push_ok),
      .inc   (pop_ok),
      .top   (top)
   );

   fpstk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (init),
      .wr_en    (push_ok || wr_req),
      .wr_addr  (st_addr),
      .wr_data  (st_data),
      .wr_tag   (st_tag),
      .clr_en   (pop_ok),
      .clr_addr (top),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .tags     (tags)
   );

   assign tag_word = tags;
   assign rd_tag   = tags[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stack_fault <= 1'b0;
         c1          <= 1'b0;
         invalid     <= 1'b0;
      end else begin
         stack_fault <= push_bad || pop_bad;
         c1          <= push_bad;
         invalid     <= push_bad || pop_bad;
      end
   end

   AST_INIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (tag_word == '1) && (top == '0)) else $error("init failed"); // R1
   AST_PUSH_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> top == PTR_W'($past(top) - 1'b1)) else $error("push pointer"); // R2
   AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |=> tags[$past(top)] == TAG_EMPTY) else $error("pop tag"); // R4
   AST_FAULT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      stack_fault |-> invalid) else $error("fault without invalid"); // R7
   AST_C1_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      c1 |-> stack_fault) else $error("c1 without fault"); // R8
   AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      stack_fault |-> (top == $past(top)) && (tag_word == $past(tag_word)))
      else $error("fault changed state"); // R9
endmodule

// File: tb/fp_regstack_test.sv
module fp_regstack_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init = 1'b0, push = 1'b0, pop = 1'b0, wr_en = 1'b0;
   logic [79:0] push_data = '0, wr_data = '0;
   logic [2:0]  rd_idx = '0, wr_idx = '0;
   logic [79:0] rd_data;
   logic [1:0]  rd_tag;
   logic [2:0]  top;
   logic [15:0] tag_word;
   logic        stack_fault, c1, invalid;
   int checks = 0;
   int errors = 0;

   localparam logic [79:0] NRM = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
   localparam logic [79:0] ZER = '0;
   localparam logic [79:0] INF = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
   localparam logic [79:0] DEN = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};

   always #4 clk = ~clk;

   fp_regstack uut (
      .clk(clk), .rst_n(rst_n), .init(init), .push(push), .push_data(push_data),
      .pop(pop), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .top(top),
      .tag_word(tag_word), .stack_fault(stack_fault), .c1(c1), .invalid(invalid)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_push(input logic [79:0] v);
      push = 1'b1; push_data = v; tick(); push = 1'b0;
   endtask

   task automatic do_pop();
      pop = 1'b1; tick(); pop = 1'b0;
   endtask

   task automatic do_init();
      init = 1'b1; tick(); init = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "tag_word after reset", 80'(tag_word), 80'hFFFF);
      chk("R1", "top after reset", 80'(top), 80'd0);
      chk("R1", "fault after reset", 80'({stack_fault, c1, invalid}), 80'd0);
   endtask

   task automatic t_push_classify();
      do_push(NRM);
      chk("R2", "top after first push", 80'(top), 80'd7);
      chk("R2", "tag_word after nonzero push", 80'(tag_word), 80'h3FFF);
      do_push(ZER);
      chk("R3", "tag_word after zero push", 80'(tag_word), 80'h1FFF);
      do_push(INF);
      chk("R3", "tag_word after infinity push", 80'(tag_word), 80'h1BFF);
      do_push(DEN);
      chk("R3", "tag_word after denormal push", 80'(tag_word), 80'h1AFF);
      chk("R2", "top after four pushes", 80'(top), 80'd4);
      rd_idx = 3'd0; #1;
      chk("R5", "ST0 data", rd_data, DEN);
      rd_idx = 3'd3; #1;
      chk("R5", "ST3 data", rd_data, NRM);
      rd_idx = 3'd1; #1;
      chk("R5", "ST1 tag", 80'(rd_tag), 80'd2);
   endtask

   task automatic t_write();
      wr_en = 1'b1; wr_idx = 3'd1; wr_data = ZER; tick(); wr_en = 1'b0;
      chk("R6", "tag_word after write", 80'(tag_word), 80'h16FF);
      rd_idx = 3'd1; #1;
      chk("R6", "ST1 data after write", rd_data, ZER);
      wr_en = 1'b1; wr_idx = 3'd1; wr_data = NRM; pop = 1'b1; tick();
      wr_en = 1'b0; pop = 1'b0;
      chk("R4", "top after pop", 80'(top), 80'd5);
      chk("R4", "tag_word after pop", 80'(tag_word), 80'h17FF);
      rd_idx = 3'd0; #1;
      chk("R6", "write ignored during pop", rd_data, ZER);
      chk("R8", "no fault after good pop", 80'(stack_fault), 80'd0);
   endtask

   task automatic t_underflow();
      do_pop(); do_pop(); do_pop();
      chk("R4", "top after draining", 80'(top), 80'd0);
      chk("R4", "tag_word after draining", 80'(tag_word), 80'hFFFF);
      do_pop();
      chk("R8", "fault on empty pop", 80'({stack_fault, c1, invalid}), 80'b101);
      chk("R9", "top after empty pop", 80'(top), 80'd0);
      chk("R9", "tags after empty pop", 80'(tag_word), 80'hFFFF);
      tick();
      chk("R8", "fault cleared", 80'({stack_fault, c1, invalid}), 80'd0);
   endtask

   task automatic t_overflow();
      for (int k = 0; k < 8; k++)
         do_push({1'b0, 15'h4000, 64'h8000_0000_0000_0000 | 64'(k)});
      chk("R2", "top after eight pushes", 80'(top), 80'd0);
      chk("R3", "full tag_word", 80'(tag_word), 80'h0000);
      do_push(INF);
      chk("R7", "fault on full push", 80'({stack_fault, c1, invalid}), 80'b111);
      chk("R9", "top after full push", 80'(top), 80'd0);
      chk("R9", "tags after full push", 80'(tag_word), 80'h0000);
      rd_idx = 3'd0; #1;
      chk("R9", "ST0 kept", rd_data, {1'b0, 15'h4000, 64'h8000_0000_0000_0007});
      rd_idx = 3'd7; #1;
      chk("R9", "R7 kept", rd_data, {1'b0, 15'h4000, 64'h8000_0000_0000_0000});
      push = 1'b1; pop = 1'b1; push_data = INF; tick(); push = 1'b0; pop = 1'b0;
      chk("R10", "push wins on full stack", 80'({stack_fault, c1}), 80'b11);
      chk("R10", "top unchanged", 80'(top), 80'd0);
   endtask

   task automatic t_init_and_priority();
      do_init();
      chk("R1", "tag_word after init", 80'(tag_word), 80'hFFFF);
      chk("R1", "top after init", 80'(top), 80'd0);
      do_push(NRM);
      push = 1'b1; pop = 1'b1; push_data = ZER; tick(); push = 1'b0; pop = 1'b0;
      chk("R10", "top after push with pop", 80'(top), 80'd6);
      chk("R10", "tags after push with pop", 80'(tag_word), 80'h1FFF);
      init = 1'b1; push = 1'b1; push_data = NRM; tick(); init = 1'b0; push = 1'b0;
      chk("R1", "init beats push", 80'({top, tag_word}), 80'h0FFFF);
   endtask

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_push_classify();
      t_write();
      t_underflow();
      t_overflow();
      t_init_and_priority();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule